// File: doc/BRIEF.md
# Timeslot Connection Store with Change Detect

This block keeps one 16-bit control word for every output timeslot of a time-division switch. It streams the words out in timeslot order, and each word steers a companion data memory for the slot it belongs to. A slot counter picks the word to read. A frame pulse clears the counter. The counter advances either once per clock or once every two clocks, as the rate input selects. The top module also splits the streamed word into its control fields, so a neighbouring data memory can take them directly.

A processor reads and writes the stored words through an asynchronous port. The port has an active-low select, an active-low strobe, a read/write line and an address. Completion is signalled on an active-low acknowledge some clocks after the strobe falls, and the acknowledge is released once the strobe returns high.

Every frame, the block folds the words it streams into a CRC-16-CCITT. It compares the result with the value from the previous frame, and a mismatch pulls an active-low change flag. Processor writes move the reference without raising the flag. A strobe issued while the block is selected clears the flag.

Top module: `tsi_conn_store`

## Requirements
- R1: The frame pulse `fp_n` is active low and lasts one clock. When it is sampled low, the slot counter returns to zero. `word_out` shows the word at address 0 from the following clock edge onwards.
- R2: With `rate_full` high, the slot counter steps by one on every clock and wraps from 2^ADDR_W-1 to 0. On each edge, `word_out` loads the word at the slot address that was current before that edge.
- R3: With `rate_full` low, the slot counter steps once every two clocks, so each word stays on `word_out` for two clocks. The phase restarts at the frame pulse.
- R4: The control fields come from `word_out` as follows: `src_ch` = bits 9:0, `out_en` = bit 10, `msg_en` = bit 11, `buf_sel` = bit 12, `ext_drv` = bit 13. Bits 15:14 carry no function. For example, 0x2001 gives channel 1 with `ext_drv` set.
- R5: A write has `rw` = 0. Call edge 0 the first edge that samples `ds_n` low while `cs_n` is low. The word is stored at edge 3 and reaches the stream from edge 4. `dta_n` goes low after edge 4. If edge r is the first edge to sample `ds_n` high again, `dta_n` returns high after edge r+2.
- R6: A read has `rw` = 1 and uses the same timing as a write. `rdata` holds the addressed word after edge 3, and `dta_n` goes low after edge 4.
- R7: A strobe given while `cs_n` is high is ignored. No acknowledge is given and no word is stored.
- R8: At each frame boundary, the CRC-16-CCITT (polynomial 0x1021, seed 0xFFFF, MSB first) is taken over the words streamed in that frame, counting one word per slot. It is compared with the previous frame's CRC. If they differ, `cd_n` goes low after the edge that follows the frame-pulse edge. The first boundary after reset only records a reference.
- R9: The frame that holds a processor write and the frame after it only record a reference. Neither can pull `cd_n` low.
- R10: `cd_n` returns high after edge 2, where edge 0 is the first edge that samples `ds_n` low while `cs_n` is low. If a set and a clear fall on the same edge, the set wins.
- R11: During reset, `dta_n` and `cd_n` are high, and `word_out` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse, one clock wide |
| rate_full | input | 1 | 1: one word per clock; 0: one word per two clocks |
| cs_n | input | 1 | Processor select, active low |
| ds_n | input | 1 | Processor strobe, active low, asynchronous |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Processor word address |
| wdata | input | 16 | Processor write data |
| rdata | output | 16 | Processor read data |
| dta_n | output | 1 | Transfer acknowledge, active low |
| cd_n | output | 1 | Change-detect flag, active low |
| word_out | output | 16 | Streamed control word |
| src_ch | output | 10 | Source channel field |
| out_en | output | 1 | Output-enable field |
| msg_en | output | 1 | Message-enable field |
| buf_sel | output | 1 | Buffering-mode field |
| ext_drv | output | 1 | External-driver-enable field |

## Verification
The port assertions assume that the processor keeps `cs_n`, `rw`, `addr` and `wdata` steady from the fall of `ds_n` until `dta_n` has gone low. They also assume `ds_n` stays low until that acknowledge appears. The stimulus tasks change the access signals only when they assert or release the strobe, and they release it only after seeing the acknowledge. The frame-pulse assertions expect a pulse that is one clock wide; the frame generator in the bench produces only such pulses, including when the frame length or the rate is changed while running.

// File: rtl/tsi_cs_pkg.sv
// Package: shared constants, port state encoding and CRC step for the
// timeslot connection store.
// Assumes 16-bit control words; the CRC folds a word MSB first.
package tsi_cs_pkg;

    localparam int WORD_W       = 16;
    localparam int CH_W         = 10;
    localparam int BIT_OUT_EN   = 10;
    localparam int BIT_MSG_EN   = 11;
    localparam int BIT_BUF_SEL  = 12;
    localparam int BIT_EXT_DRV  = 13;
    localparam int GUARD_FRAMES = 2;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_ACCESS,
        PORT_SETTLE,
        PORT_ACK
    } port_state_t;

    // Fold one data word into a running CRC-16-CCITT, MSB first.
    function automatic logic [15:0] crc_fold(input logic [15:0] crc,
                                             input logic [WORD_W-1:0] data);
        logic [15:0] c;
        c = crc;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (c[15] ^ data[i])
                c = {c[14:0], 1'b0} ^ CRC_POLY;
            else
                c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/tsi_slot_counter.sv
// Slot counter: produces the read address for the stream and a flag that
// marks the first clock of each slot.
// Assumes fp_n is synchronous to clk and one clock wide.
module tsi_slot_counter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_n,
    input  logic              rate_full,
    output logic [ADDR_W-1:0] slot,
    output logic              take
);

    logic phase;

    // Advance the slot address at full or half rate; the frame pulse clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= '0;
            phase <= 1'b0;
        end else if (!fp_n) begin
            slot  <= '0;
            phase <= 1'b0;
        end else if (rate_full) begin
            slot  <= slot + 1'b1;
            phase <= 1'b0;
        end else begin
            if (phase)
                slot <= slot + 1'b1;
            phase <= ~phase;
        end
    end

    // First clock of a slot: every clock at full rate, even phase at half rate.
    assign take = rate_full | ~phase;

    // R1
    fp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_n |=> slot == '0);

    // R2
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_n && rate_full) |=> slot == ADDR_W'($past(slot) + 1'b1));

    // R3
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_n && !rate_full && take) |=> $stable(slot));

endmodule

// File: rtl/tsi_word_ram.sv
// Word store: one streaming read port and one processor port (read or
// write). Both reads are registered, and a write in the same cycle as a
// read returns the old word.
// Assumes the processor port never reads and writes in the same cycle.
module tsi_word_ram
    import tsi_cs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strm_addr,
    output logic [WORD_W-1:0] strm_q,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_re,
    input  logic [WORD_W-1:0] cpu_wd,
    output logic [WORD_W-1:0] cpu_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    // Store a processor word; the contents are not reset.
    always_ff @(posedge clk) begin
        if (cpu_we)
            store[cpu_addr] <= cpu_wd;
    end

    // Register the streamed word for the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strm_q <= '0;
        else
            strm_q <= store[strm_addr];
    end

    // Register the word the processor asked for.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_q <= '0;
        else if (cpu_re)
            cpu_q <= store[cpu_addr];
    end

    // R5
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_re));

endmodule

// File: rtl/tsi_cpu_port.sv
// Processor port: synchronises the strobe and select, performs one access
// per strobe, and drives the acknowledge. It also flags a selected strobe
// edge so that change detect can be cleared.
// Assumes select, rw, address and data are steady while the strobe is low.
module tsi_cpu_port
    import tsi_cs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [WORD_W-1:0] mem_wd,
    output logic              dta_n,
    output logic              cd_clear
);

    logic        ds_m, ds_s, ds_p;
    logic        cs_m, cs_s;
    logic        lat_rd;
    port_state_t state;

    // Two-flop synchronisers for strobe and select, plus a delayed strobe copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_m <= 1'b1;
            ds_s <= 1'b1;
            ds_p <= 1'b1;
            cs_m <= 1'b1;
            cs_s <= 1'b1;
        end else begin
            ds_m <= ds_n;
            ds_s <= ds_m;
            ds_p <= ds_s;
            cs_m <= cs_n;
            cs_s <= cs_m;
        end
    end

    // Access sequencer: capture, access, settle, then hold acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PORT_IDLE;
            lat_rd   <= 1'b1;
            mem_addr <= '0;
            mem_wd   <= '0;
        end else begin
            case (state)
                PORT_IDLE: begin
                    if (!ds_s && !cs_s) begin
                        state    <= PORT_ACCESS;
                        lat_rd   <= rw;
                        mem_addr <= addr;
                        mem_wd   <= wdata;
                    end
                end
                PORT_ACCESS: state <= PORT_SETTLE;
                PORT_SETTLE: state <= PORT_ACK;
                default: begin
                    if (ds_s)
                        state <= PORT_IDLE;
                end
            endcase
        end
    end

    // Memory strobes during the access state only.
    assign mem_we   = (state == PORT_ACCESS) && !lat_rd;
    assign mem_re   = (state == PORT_ACCESS) && lat_rd;
    assign dta_n    = (state != PORT_ACK);
    assign cd_clear = !ds_s && ds_p && !cs_s;

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dta_n) |-> $past(ds_s));

    // R6
    ack_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dta_n) |-> ($past(mem_re, 2) || $past(mem_we, 2)));

    // R7
    select_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> !$past(cs_s));

endmodule

// File: rtl/tsi_change_detect.sv
// Change detect: folds each streamed word into a CRC once per slot. At
// every frame boundary it compares the result with the previous frame and
// raises an active-low flag on a difference, unless a write guard is active.
// Assumes word_q and take arrive with the registered read of the same slot.
module tsi_change_detect
    import tsi_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_q,
    input  logic              take,
    input  logic              fp_n,
    input  logic              wr_evt,
    input  logic              cd_clear,
    output logic              cd_n
);

    logic        take_q, bnd_q;
    logic [15:0] crc_acc, crc_ref, crc_final;
    logic        ref_ok;
    logic [1:0]  guard;
    logic        cd_q;
    logic        mismatch;

    // Align the slot flag and the boundary marker with the registered word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            bnd_q  <= 1'b0;
        end else begin
            take_q <= take;
            bnd_q  <= !fp_n;
        end
    end

    // Frame CRC including the word currently presented.
    always_comb begin
        crc_final = take_q ? crc_fold(crc_acc, word_q) : crc_acc;
    end

    // Running CRC, restarted at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_acc <= CRC_SEED;
        else if (bnd_q)
            crc_acc <= CRC_SEED;
        else
            crc_acc <= crc_final;
    end

    // Reference CRC: replaced by the finished frame at every boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_ref <= '0;
            ref_ok  <= 1'b0;
        end else if (bnd_q) begin
            crc_ref <= crc_final;
            ref_ok  <= 1'b1;
        end
    end

    // Write guard: counts down the frames in which a compare is skipped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            guard <= '0;
        else if (wr_evt)
            guard <= 2'(GUARD_FRAMES);
        else if (bnd_q && guard != '0)
            guard <= guard - 1'b1;
    end

    assign mismatch = bnd_q && ref_ok && (guard == '0) && (crc_final != crc_ref);

    // Flag register: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cd_q <= 1'b0;
        else if (mismatch)
            cd_q <= 1'b1;
        else if (cd_clear)
            cd_q <= 1'b0;
    end

    assign cd_n = ~cd_q;

    // R8
    flag_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> $past(bnd_q));

    // R9
    no_flag_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> ($past(guard) == '0));

    // R10
    clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_n) |-> $past(cd_clear));

endmodule

// File: rtl/tsi_conn_store.sv
// Top: connection store. It streams one control word per timeslot, serves
// a processor port and watches the streamed contents for silent changes.
// Assumes a single clock domain for stream and frame pulse; the strobe is
// asynchronous.
module tsi_conn_store
    import tsi_cs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_n,
    input  logic              rate_full,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              dta_n,
    output logic              cd_n,
    output logic [15:0]       word_out,
    output logic [9:0]        src_ch,
    output logic              out_en,
    output logic              msg_en,
    output logic              buf_sel,
    output logic              ext_drv
);

    logic [ADDR_W-1:0] slot;
    logic              take;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we, mem_re;
    logic [WORD_W-1:0] mem_wd;
    logic              cd_clear;

    tsi_slot_counter #(.ADDR_W(ADDR_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_n      (fp_n),
        .rate_full (rate_full),
        .slot      (slot),
        .take      (take)
    );

    tsi_word_ram #(.ADDR_W(ADDR_W)) i_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .strm_addr (slot),
        .strm_q    (word_out),
        .cpu_addr  (mem_addr),
        .cpu_we    (mem_we),
        .cpu_re    (mem_re),
        .cpu_wd    (mem_wd),
        .cpu_q     (rdata)
    );

    tsi_cpu_port #(.ADDR_W(ADDR_W)) i_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .ds_n     (ds_n),
        .rw       (rw),
        .addr     (addr),
        .wdata    (wdata),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_wd   (mem_wd),
        .dta_n    (dta_n),
        .cd_clear (cd_clear)
    );

    tsi_change_detect i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_q   (word_out),
        .take     (take),
        .fp_n     (fp_n),
        .wr_evt   (mem_we),
        .cd_clear (cd_clear),
        .cd_n     (cd_n)
    );

    // Split the streamed word into its control fields.
    assign src_ch  = word_out[CH_W-1:0];
    assign out_en  = word_out[BIT_OUT_EN];
    assign msg_en  = word_out[BIT_MSG_EN];
    assign buf_sel = word_out[BIT_BUF_SEL];
    assign ext_drv = word_out[BIT_EXT_DRV];

endmodule

// File: tb/test_tsi_conn_store.sv
`timescale 1ns/1ps
module test_tsi_conn_store;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fp_n = 1'b1;
    logic          rate_full = 1'b1;
    logic          cs_n = 1'b1;
    logic          ds_n = 1'b1;
    logic          rw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata, word_out;
    logic          dta_n, cd_n, out_en, msg_en, buf_sel, ext_drv;
    logic [9:0]    src_ch;

    tsi_conn_store #(.ADDR_W(AW)) i_tsi_conn_store (
        .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .rate_full(rate_full),
        .cs_n(cs_n), .ds_n(ds_n), .rw(rw), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dta_n(dta_n), .cd_n(cd_n), .word_out(word_out),
        .src_ch(src_ch), .out_en(out_en), .msg_en(msg_en),
        .buf_sel(buf_sel), .ext_drv(ext_drv)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit word_chk_en = 0;
    int frame_len = 64;
    int fcnt = 0;

    // Reference model state
    logic [15:0] mmem [DEPTH];
    int          m_slot, m_phase, m_guard;
    logic [15:0] m_word;
    logic        m_cd;
    bit          m_bnd, m_after_fp, prv_ok;
    logic [15:0] cur [$];
    logic [15:0] prv [$];
    bit          dsh1, dsh2, dsh3, csh1, csh2;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit q_same(input logic [15:0] a[$], input logic [15:0] b[$]);
        if (a.size() != b.size()) return 0;
        foreach (a[i]) if (a[i] !== b[i]) return 0;
        return 1;
    endfunction

    function automatic logic [15:0] pat(input int i);
        return 16'h8000 | 16'((i * 16'h0123) ^ 16'h0A5A);
    endfunction

    // Frame pulse generator, one clock wide
    always @(negedge clk) begin
        if (fcnt >= frame_len - 1) begin
            fp_n = 1'b0;
            fcnt = 0;
        end else begin
            fp_n = 1'b1;
            fcnt++;
        end
    end

    // Behavioural model, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0; m_phase = 0; m_guard = 0; m_word = '0; m_cd = 1'b1;
            m_bnd = 0; m_after_fp = 0; prv_ok = 0;
            cur.delete(); prv.delete();
            dsh1 = 1; dsh2 = 1; dsh3 = 1; csh1 = 1; csh2 = 1;
        end else begin
            bit set_cd, clr;
            set_cd = 0;
            if (m_bnd) begin
                if (prv_ok && m_guard == 0 && !q_same(cur, prv)) set_cd = 1;
                if (m_guard > 0) m_guard--;
                prv = cur; prv_ok = 1; cur.delete();
            end
            clr = (dsh2 == 0) && (dsh3 == 1) && (csh2 == 0);
            dsh3 = dsh2; dsh2 = dsh1; dsh1 = ds_n; csh2 = csh1; csh1 = cs_n;
            if (set_cd) m_cd = 1'b0;
            else if (clr) m_cd = 1'b1;
            m_after_fp = m_bnd;
            m_word = mmem[m_slot];
            if (rate_full || m_phase == 0) cur.push_back(m_word);
            m_bnd = !fp_n;
            if (!fp_n) begin
                m_slot = 0; m_phase = 0;
            end else if (rate_full) begin
                m_slot = (m_slot + 1) % DEPTH; m_phase = 0;
            end else begin
                if (m_phase == 1) m_slot = (m_slot + 1) % DEPTH;
                m_phase = 1 - m_phase;
            end
        end
    end

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 R10 cd_n", cd_n, m_cd);
            if (word_chk_en) begin
                if (m_after_fp)     chk("R1 word after frame pulse", word_out, m_word);
                else if (rate_full) chk("R2 stream word", word_out, m_word);
                else                chk("R3 stream word", word_out, m_word);
                chk("R4 fields", {ext_drv, buf_sel, msg_en, out_en, src_ch}, m_word[13:0]);
            end
        end
    end

    task automatic cpu_write(input int a, input logic [15:0] d);
        @(negedge clk);
        cs_n = 0; rw = 0; addr = AW'(a); wdata = d; ds_n = 0;
        repeat (4) @(negedge clk);
        chk("R5 no ack before edge 4", dta_n, 1'b1);
        mmem[a] = d; m_guard = 2;
        @(negedge clk);
        chk("R5 ack after edge 4", dta_n, 1'b0);
        ds_n = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 ack held through r+1", dta_n, 1'b0);
        @(negedge clk);
        chk("R5 ack released after r+2", dta_n, 1'b1);
        cs_n = 1; rw = 1;
    endtask

    task automatic cpu_read(input int a);
        @(negedge clk);
        cs_n = 0; rw = 1; addr = AW'(a); ds_n = 0;
        repeat (4) @(negedge clk);
        chk("R6 no ack before edge 4", dta_n, 1'b1);
        chk("R6 data after edge 3", rdata, mmem[a]);
        @(negedge clk);
        chk("R6 ack after edge 4", dta_n, 1'b0);
        ds_n = 1;
        repeat (3) @(negedge clk);
        chk("R6 ack released", dta_n, 1'b1);
        cs_n = 1;
    endtask

    initial begin
        foreach (mmem[i]) mmem[i] = '0;
        repeat (4) @(negedge clk);
        chk("R11 dta_n in reset", dta_n, 1'b1);
        chk("R11 cd_n in reset", cd_n, 1'b1);
        chk("R11 word_out in reset", word_out, 16'h0);
        chk("R11 rdata in reset", rdata, 16'h0);
        rst_n = 1;

        for (int i = 0; i < DEPTH; i++) cpu_write(i, pat(i));
        word_chk_en = 1;
        repeat (3 * 64) @(negedge clk);
        chk("R9 writes raise no flag", cd_n, 1'b1);

        cpu_read(5);
        cpu_read(DEPTH - 1);

        cpu_write(7, 16'h2001);
        begin
            bit seen;
            seen = 0;
            for (int k = 0; k < 300 && !seen; k++) begin
                @(negedge clk);
                if (word_out == 16'h2001) seen = 1;
            end
            chk("R4 word 0x2001 streamed", seen, 1'b1);
            chk("R4 src_ch of 0x2001", src_ch, 10'd1);
            chk("R4 ext_drv of 0x2001", ext_drv, 1'b1);
            chk("R4 out_en of 0x2001", out_en, 1'b0);
        end

        repeat (4 * 64) @(negedge clk);
        chk("R8 steady contents keep flag high", cd_n, 1'b1);

        frame_len = 100;
        repeat (4 * 100) @(negedge clk);
        chk("R8 changed frame contents flagged", cd_n, 1'b0);
        cpu_read(3);
        chk("R10 strobe clears flag", cd_n, 1'b1);
        repeat (3 * 100) @(negedge clk);
        chk("R8 stable wrapped frames", cd_n, 1'b1);

        rate_full = 0;
        frame_len = 40;
        repeat (5 * 40) @(negedge clk);
        chk("R8 rate change flagged", cd_n, 1'b0);
        cpu_read(9);
        chk("R10 strobe clears flag at half rate", cd_n, 1'b1);

        cpu_write(2, 16'h1C05);
        repeat (4 * 40) @(negedge clk);
        chk("R9 write at half rate raises no flag", cd_n, 1'b1);

        @(negedge clk);
        cs_n = 1; rw = 0; addr = AW'(10); wdata = 16'hDEAD; ds_n = 0;
        repeat (10) @(negedge clk);
        chk("R7 no ack when deselected", dta_n, 1'b1);
        ds_n = 1; rw = 1;
        repeat (3) @(negedge clk);
        cpu_read(10);
        chk("R7 word unchanged", mmem[10], pat(10));
        repeat (2 * 40) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule